// File: doc/BRIEF.md
# Tuner Synthesiser I2C Register Interface

This block is the serial control port of a frequency synthesiser for a tuner. It runs as an I2C target on the system clock. It samples the SCL and SDA lines, filters them, and finds START and STOP conditions and clock edges. It then moves bytes in and out, and drives SDA low through an open-drain enable. Written data lands in three registers: a 15-bit divider ratio, a 7-bit control word (charge-pump current, test enables, mode-select bits and drive disable), and a 6-bit port-switch word. A read returns a status byte built from a power-on flag, the lock detector and the levels of the digital and ADC inputs.

A write session may carry any number of byte pairs. The top bit of the first byte of each pair picks the destination. The second byte completes the pair, and only then does the destination register change, so downstream logic never sees a half-written divider ratio. Several synthesisers can share one bus. Each accepts one fixed address, and also the one address picked by a two-bit select code that is decoded elsewhere from an analog strap.

Top module: `tuner_synth_regif`

## Requirements
- R1: An address byte is 1,1,0,0,0,MA1,MA0,RW, sent MSB first. The block drives SDA low in the ninth clock only when the top five bits match. MA1:MA0 = 01 always matches. Codes 00, 10 and 11 match only when `addr_sel_i` holds the same value.
- R2: After an address that does not match, the block leaves SDA released and changes no register for every byte until the next START.
- R3: In a write session, a first-of-pair byte with bit 7 = 0 opens a divider pair. Its bits 6..0 become ratio bits 14..8, and the following byte supplies ratio bits 7..0.
- R4: A first-of-pair byte with bit 7 = 1 opens a control pair. Its bits 6..0 become `ctrl_o[6:0]` (CP, T1, T0, TS2, TS1, TS0, OS from bit 6 down). The following byte drives `port_o` = {b[7], b[6], b[5], b[4], b[3], b[0]} (P7, P6, P5, P4, P3, P0). Its bits 2 and 1 are ignored.
- R5: Every complete byte received after a matching write address is acknowledged by SDA low in the ninth clock.
- R6: A register changes only when the second byte of its pair completes, and both halves take effect in the same cycle. Further pairs may follow in one session without a new address.
- R7: A byte cut short by STOP, or a pair left with only its first byte at START or STOP, leaves every register unchanged. The next data byte opens a new pair.
- R8: A read returns the status byte POR, FL, I2, I1, I0, A2, A1, A0 MSB first, with I2..I0 = `port_lvl_i[2:0]` (P7, P5, P4) and A2..A0 = `adc_i`. The byte is sampled again each time it is loaded.
- R9: While the controller acknowledges, the status byte is sent again. A missing acknowledge ends the read: SDA stays released for all further clocks until a START.
- R10: The POR bit is 1 after reset and is cleared only by a STOP that closes a session whose last address was a read.
- R11: While `rst_n` is low, all registers are zero (every port off, high impedance) and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| addr_sel_i | input | 2 | Strap-decoded address select code MA1:MA0 |
| lock_i | input | 1 | Phase-lock indication for the status byte |
| port_lvl_i | input | 3 | Levels of ports P7, P5, P4 |
| adc_i | input | 3 | ADC code for the status byte |
| div_ratio_o | output | 15 | Programmable divider ratio |
| ctrl_o | output | 7 | CP, T1, T0, TS2, TS1, TS0, OS |
| port_o | output | 6 | Port switches P7, P6, P5, P4, P3, P0 (1 = on) |

## Verification
The assertions check four things on every cycle. A register moves only in the cycle after a pair commits. A half-received pair is always dropped at a START or STOP. The POR flag falls only after a STOP. SDA is newly pulled low only just after a filtered SCL fall, and never after a STOP. Some behaviour only the bench scenarios can show: which address codes match under each select value, the field placement of both pair kinds, status bytes that follow changing inputs, the released line after a missing controller acknowledge, and the survival of old data after truncated bytes and half pairs.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 15;
  localparam int CTRL_W = 7;
  localparam int PORT_W = 6;
  localparam int CNT_W  = $clog2(BYTE_W);

  // fixed upper address bits and the select code that is always accepted
  localparam logic [4:0] DEV_ID    = 5'b11000;
  localparam logic [1:0] MA_ALWAYS = 2'b01;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDATA, S_WACK, S_RDATA, S_RACK
  } bus_state_t;

  // address match on bits 7..1 of the address byte (bit 0 is R/W)
  function automatic logic addr_hit(input logic [7:1] b, input logic [1:0] sel);
    return (b[7:3] == DEV_ID) && ((b[2:1] == MA_ALWAYS) || (b[2:1] == sel));
  endfunction

  function automatic logic [BYTE_W-1:0] pack_status(input logic por, input logic lock,
                                                     input logic [2:0] lvl, input logic [2:0] adc);
    return {por, lock, lvl, adc};
  endfunction

  // second byte of a control pair: P7..P3 from bits 7..3, P0 from bit 0
  function automatic logic [PORT_W-1:0] port_bits(input logic [BYTE_W-1:0] b);
    return {b[7:3], b[0]};
  endfunction

  function automatic logic [DIV_W-1:0] div_join(input logic [BYTE_W-1:0] hi,
                                                 input logic [BYTE_W-1:0] lo);
    return {hi[6:0], lo};
  endfunction
endpackage

// File: rtl/tsr_line_filter.sv
module tsr_line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  // two-flop synchroniser, then the output follows only after FILT_LEN stable samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      run_q  <= '0;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], din};
      if (sync_q[1] == dout) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        dout  <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsr_bus_events.sv
module tsr_bus_events #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_bit,
  output logic ev_scl_rise,
  output logic ev_scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw, filt;
  logic scl_q, sda_q;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    tsr_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw[g]),
      .dout (filt[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= filt[1];
      sda_q <= filt[0];
    end
  end

  assign sda_bit     = filt[0];
  assign ev_scl_rise = filt[1] & ~scl_q;
  assign ev_scl_fall = ~filt[1] & scl_q;
  assign ev_start    = filt[1] & scl_q & sda_q & ~filt[0];
  assign ev_stop     = filt[1] & scl_q & ~sda_q & filt[0];
endmodule

// File: rtl/tsr_slave_fsm.sv
module tsr_slave_fsm
  import tsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_bit,
  input  logic              ev_scl_rise,
  input  logic              ev_scl_fall,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic [1:0]        addr_sel,
  input  logic [BYTE_W-1:0] status_byte,
  output logic              sda_oe,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_val,
  output logic              rd_stop
);
  bus_state_t        st;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] sh, tx;
  logic              full, rnw, mack, rd_sess;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bitcnt   <= '0;
      sh       <= '0;
      tx       <= '1;
      full     <= 1'b0;
      rnw      <= 1'b0;
      mack     <= 1'b0;
      rd_sess  <= 1'b0;
      byte_stb <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      if (ev_start) begin
        st      <= S_ADDR;
        bitcnt  <= '0;
        full    <= 1'b0;
        rd_sess <= 1'b0;
      end else if (ev_stop) begin
        st      <= S_IDLE;
        full    <= 1'b0;
        rd_sess <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_WDATA: begin
            if (ev_scl_rise) begin
              sh     <= {sh[BYTE_W-2:0], sda_bit};
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == CNT_W'(BYTE_W - 1)) full <= 1'b1;
            end else if (ev_scl_fall && full) begin
              full <= 1'b0;
              if (st == S_ADDR) begin
                if (addr_hit(sh[7:1], addr_sel)) begin
                  st  <= S_AACK;
                  rnw <= sh[0];
                end else begin
                  st <= S_IDLE;
                end
              end else begin
                st       <= S_WACK;
                byte_stb <= 1'b1;
              end
            end
          end
          S_AACK: begin
            if (ev_scl_fall) begin
              bitcnt <= '0;
              if (rnw) begin
                st      <= S_RDATA;
                tx      <= status_byte;
                rd_sess <= 1'b1;
              end else begin
                st <= S_WDATA;
              end
            end
          end
          S_WACK: begin
            if (ev_scl_fall) begin
              st     <= S_WDATA;
              bitcnt <= '0;
            end
          end
          S_RDATA: begin
            if (ev_scl_fall) begin
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == CNT_W'(BYTE_W - 1)) st <= S_RACK;
              else tx <= {tx[BYTE_W-2:0], 1'b1};
            end
          end
          S_RACK: begin
            if (ev_scl_rise) begin
              mack <= ~sda_bit;
            end else if (ev_scl_fall) begin
              if (mack) begin
                st     <= S_RDATA;
                tx     <= status_byte;
                bitcnt <= '0;
              end else begin
                st <= S_IDLE;   // missing acknowledge: behave as if stopped
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign byte_val = sh;
  assign rd_stop  = ev_stop & rd_sess;
  assign sda_oe   = (st == S_AACK) || (st == S_WACK) || ((st == S_RDATA) && !tx[BYTE_W-1]);
endmodule

// File: rtl/tsr_reg_bank.sv
module tsr_reg_bank
  import tsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              frame_edge,
  input  logic              rd_stop,
  output logic [DIV_W-1:0]  div_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [PORT_W-1:0] port_o,
  output logic              por_flag,
  output logic              pair_commit,
  output logic              pair_pending
);
  logic [BYTE_W-1:0] first_q;

  assign pair_commit = byte_stb & pair_pending & ~frame_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q      <= '0;
      pair_pending <= 1'b0;
      div_o        <= '0;
      ctrl_o       <= '0;
      port_o       <= '0;
      por_flag     <= 1'b1;
    end else begin
      if (rd_stop) por_flag <= 1'b0;
      if (frame_edge) begin
        pair_pending <= 1'b0;
      end else if (byte_stb) begin
        if (!pair_pending) begin
          first_q      <= byte_val;
          pair_pending <= 1'b1;
        end else begin
          pair_pending <= 1'b0;
          if (first_q[BYTE_W-1]) begin
            ctrl_o <= first_q[CTRL_W-1:0];
            port_o <= port_bits(byte_val);
          end else begin
            div_o <= div_join(first_q, byte_val);
          end
        end
      end
    end
  end
endmodule

// File: rtl/tuner_synth_regif.sv
module tuner_synth_regif
  import tsr_pkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [1:0]        addr_sel_i,
  input  logic              lock_i,
  input  logic [2:0]        port_lvl_i,
  input  logic [2:0]        adc_i,
  output logic [DIV_W-1:0]  div_ratio_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [PORT_W-1:0] port_o
);
  logic              sda_bit, ev_scl_rise, ev_scl_fall, ev_start, ev_stop;
  logic              byte_stb, rd_stop, por_flag, pair_commit, pair_pending;
  logic [BYTE_W-1:0] byte_val, status_byte;

  assign status_byte = pack_status(por_flag, lock_i, port_lvl_i, adc_i);

  tsr_bus_events #(.FILT_LEN(FILT_LEN)) u_events (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_bit    (sda_bit),
    .ev_scl_rise(ev_scl_rise),
    .ev_scl_fall(ev_scl_fall),
    .ev_start   (ev_start),
    .ev_stop    (ev_stop)
  );

  tsr_slave_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_bit    (sda_bit),
    .ev_scl_rise(ev_scl_rise),
    .ev_scl_fall(ev_scl_fall),
    .ev_start   (ev_start),
    .ev_stop    (ev_stop),
    .addr_sel   (addr_sel_i),
    .status_byte(status_byte),
    .sda_oe     (sda_oe_o),
    .byte_stb   (byte_stb),
    .byte_val   (byte_val),
    .rd_stop    (rd_stop)
  );

  tsr_reg_bank u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_stb    (byte_stb),
    .byte_val    (byte_val),
    .frame_edge  (ev_start | ev_stop),
    .rd_stop     (rd_stop),
    .div_o       (div_ratio_o),
    .ctrl_o      (ctrl_o),
    .port_o      (port_o),
    .por_flag    (por_flag),
    .pair_commit (pair_commit),
    .pair_pending(pair_pending)
  );
endmodule

// File: rtl/tuner_synth_regif_chk.sv
module tuner_synth_regif_chk
  import tsr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic [DIV_W-1:0]  div,
  input logic [CTRL_W-1:0] ctrl,
  input logic [PORT_W-1:0] port,
  input logic              ev_scl_fall,
  input logic              ev_start,
  input logic              ev_stop,
  input logic              pair_commit,
  input logic              pair_pending,
  input logic              por_flag
);
  // R6
  div_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div != $past(div)) |-> $past(pair_commit));

  // R6
  ctrl_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({ctrl, port} != $past({ctrl, port})) |-> $past(pair_commit));

  // R7
  half_pair_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start || ev_stop) |=> !pair_pending);

  // R10
  por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_flag) |-> $past(ev_stop));

  // R5
  drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(ev_scl_fall));

  // R9
  release_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe);
endmodule

bind tuner_synth_regif tuner_synth_regif_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sda_oe      (sda_oe_o),
  .div         (div_ratio_o),
  .ctrl        (ctrl_o),
  .port        (port_o),
  .ev_scl_fall (ev_scl_fall),
  .ev_start    (ev_start),
  .ev_stop     (ev_stop),
  .pair_commit (pair_commit),
  .pair_pending(pair_pending),
  .por_flag    (por_flag)
);

// File: tb/tuner_synth_regif_bench.sv
module tuner_synth_regif_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 20;      // quarter bit time in clocks
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] addr_sel = 2'b00;
  logic lock = 1'b0;
  logic [2:0] lvl = 3'b000, adc = 3'b000;
  logic sda_oe, sda_line;
  logic [14:0] div_o;
  logic [6:0]  ctrl_o;
  logic [5:0]  port_o;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0, mon_hold = 1'b1;

  // expected register image {div, ctrl, port}
  logic [27:0] exp_q[$];
  logic [27:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  tuner_synth_regif u_tuner_synth_regif (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .lock_i(lock), .port_lvl_i(lvl), .adc_i(adc),
    .div_ratio_o(div_o), .ctrl_o(ctrl_o), .port_o(port_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard driver side: expected effect of one complete pair
  task automatic plan_pair(input logic [7:0] b0, input logic [7:0] b1);
    logic [27:0] nx;
    nx = model;
    if (b0[7]) nx[12:0] = {b0[6:0], b1[7:3], b1[0]};      // R4
    else       nx[27:13] = {b0[6:0], b1};                // R3
    if (nx != model) exp_q.push_back(nx);
    model = nx;
  endtask

  // scoreboard monitor side
  initial begin
    logic [27:0] prev, cur, e;
    prev = '0;
    forever begin
      @(negedge clk);
      cur = {div_o, ctrl_o, port_o};
      if (mon_hold) prev = cur;
      else if (cur != prev) begin
        if (exp_q.size() == 0) chk("R6", "unexpected register update", cur, prev);
        else begin
          e = exp_q.pop_front();
          chk("R6", "register image after pair", cur, e);
        end
        prev = cur;
      end
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic ack;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = ~sda_line;
    tick(Q); scl_m = 1'b0; tick(Q);
    chk(req, "acknowledge", 32'(ack), 32'(exp_ack));
  endtask

  task automatic recv_byte(input logic mack, input logic [7:0] exp, input string req);
    logic [7:0] v;
    v = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl_m = 1'b1; tick(Q);
      v = {v[6:0], sda_line};
      tick(Q); scl_m = 1'b0;
    end
    tick(Q); sda_m = ~mack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
    chk(req, "status byte", 32'(v), 32'(exp));
  endtask

  task automatic write_pair(input logic [7:0] b0, input logic [7:0] b1);
    plan_pair(b0, b1);
    send_byte(b0, 1'b1, "R5");
    send_byte(b1, 1'b1, "R5");
  endtask

  task automatic drained(input string req);
    tick(10);
    chk(req, "pending expected updates", 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    tick(WATCHDOG);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(5);
    // R11: reset state
    chk("R11", "divider in reset", 32'(div_o), 32'd0);
    chk("R11", "control in reset", 32'(ctrl_o), 32'd0);
    chk("R11", "ports in reset", 32'(port_o), 32'd0);
    chk("R11", "sda drive in reset", 32'(sda_oe), 32'd0);
    rst_n = 1'b1; tick(5); mon_hold = 1'b0; tick(5);

    // R1 R3: divider pair via always-valid address
    bus_start(); send_byte(8'hC2, 1'b1, "R1");
    write_pair(8'h12, 8'h34);
    bus_stop(); drained("R3");
    chk("R3", "divider value", 32'(div_o), 32'h1234);

    // R4 R6: several pairs in one session
    bus_start(); send_byte(8'hC2, 1'b1, "R1");
    write_pair(8'hCE, 8'hA5);
    chk("R4", "control field", 32'(ctrl_o), 32'h4E);
    chk("R4", "port field", 32'(port_o), 32'h29);
    write_pair(8'h7F, 8'hFF);
    chk("R3", "divider maximum", 32'(div_o), 32'h7FFF);
    write_pair(8'h81, 8'h06);
    chk("R4", "ignored port bits", 32'(port_o), 32'h00);
    bus_stop(); drained("R6");

    // R1 R2: selectable addresses
    addr_sel = 2'b10;
    bus_start(); send_byte(8'hC4, 1'b1, "R1");
    write_pair(8'h05, 8'h55);
    bus_stop(); drained("R1");
    bus_start(); send_byte(8'hC6, 1'b0, "R2");
    send_byte(8'h00, 1'b0, "R2"); send_byte(8'h11, 1'b0, "R2");
    bus_stop();
    bus_start(); send_byte(8'hC0, 1'b0, "R1"); bus_stop();
    bus_start(); send_byte(8'hD2, 1'b0, "R1"); bus_stop();
    drained("R2");
    chk("R2", "divider kept", 32'(div_o), 32'h0555);
    addr_sel = 2'b11;
    bus_start(); send_byte(8'hC6, 1'b1, "R1");
    write_pair(8'h01, 8'h02);
    bus_stop(); drained("R1");

    // R7: truncated byte and half pairs
    bus_start(); send_byte(8'hC2, 1'b1, "R1");
    send_byte(8'h03, 1'b1, "R5");
    for (int i = 7; i >= 4; i--) send_bit(1'b0);
    bus_stop();
    bus_start(); send_byte(8'hC2, 1'b1, "R1");
    send_byte(8'hAA, 1'b1, "R5");
    bus_stop(); drained("R7");
    chk("R7", "divider after truncation", 32'(div_o), 32'h0102);
    chk("R7", "control after half pair", 32'(ctrl_o), 32'h01);
    bus_start(); send_byte(8'hC2, 1'b1, "R1");
    write_pair(8'h04, 8'h56);
    bus_stop(); drained("R7");
    chk("R7", "fresh pair after drop", 32'(div_o), 32'h0456);

    // R8 R9 R10: reads
    lock = 1'b1; lvl = 3'b101; adc = 3'b010;
    bus_start(); send_byte(8'hC3, 1'b1, "R1");
    recv_byte(1'b1, 8'hEA, "R10");
    lock = 1'b0; lvl = 3'b011; adc = 3'b100;
    recv_byte(1'b1, 8'hEA, "R9");
    recv_byte(1'b0, 8'h9C, "R8");
    recv_byte(1'b0, 8'hFF, "R9");
    bus_stop();
    bus_start(); send_byte(8'hC3, 1'b1, "R1");
    recv_byte(1'b0, 8'h1C, "R10");
    bus_stop();

    // R11 R10: reset mid-run
    mon_hold = 1'b1;
    rst_n = 1'b0; tick(5);
    chk("R11", "divider cleared", 32'(div_o), 32'd0);
    chk("R11", "ports cleared", 32'(port_o), 32'd0);
    rst_n = 1'b1; model = '0; tick(5); mon_hold = 1'b0;
    bus_start(); send_byte(8'hC3, 1'b1, "R1");
    recv_byte(1'b0, 8'h9C, "R10");
    bus_stop(); drained("R11");

    finish_run();
  end
endmodule